// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a stream of instruction bytes, one per clock over a valid/ready handshake, and works out where each instruction ends. It handles a fixed table of one-byte-opcode instructions. For each one it collects the opcode, the optional addressing byte, the displacement and the immediate into a single record. The record is presented on a valid/ready output port together with the byte count and an illegal-opcode flag.

The instruction length depends on three things: the opcode class, the mode and register/memory fields of the addressing byte, and the immediate width of the opcode. The addressing-byte fields are mode in bits 7..6 and register/memory in bits 2..0. Mode 00 with register/memory 110 is the direct-offset case. Register-in-opcode short forms and the segment push/pop short forms each take one byte.

The record stays in place until it is accepted. While a record is waiting, the input side does not take any bytes.

Top module: `ilp_parser`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: The following opcodes are complete in one byte, with no addressing byte and zero displacement and immediate: 98h, 99h, C3h, 40h–47h, 50h–57h, and the segment push/pop forms 06h, 07h, 0Eh, 16h, 17h, 1Eh, 1Fh.
- R3: Opcodes C2h and 05h take a 16-bit immediate, low byte first, and are 3 bytes long.
- R4: Opcodes A1h and A2h take a 16-bit direct offset, low byte first, with no addressing byte. The offset is reported in the displacement field and the length is 3.
- R5: Opcode EAh takes a 16-bit offset, reported as the displacement, and then a 16-bit selector, reported as the immediate. Both arrive low byte first and the length is 5.
- R6: Opcodes 01h, 03h, 29h, 2Bh, 88h, 89h, 8Ah, 8Bh, 8Ch, 8Eh, FEh and FFh take one addressing byte and no immediate. The displacement that follows depends on the addressing byte:
  - mode 11: no displacement.
  - mode 00: no displacement, except with register/memory 110, which takes 2 bytes.
  - mode 01: a 1-byte displacement, sign-extended to 16 bits.
  - mode 10: a 2-byte displacement, low byte first.
- R7: Opcode 81h takes an addressing byte, then any displacement (sized as in R6), then a 16-bit immediate, low byte first.
- R8: Opcode 83h takes an addressing byte, then any displacement, then an 8-bit immediate that is sign-extended to 16 bits in the record.
- R9: Any other opcode ends the record after one byte, with out_illegal set, length 1, no addressing byte, and zero displacement and immediate.
- R10: While out_valid is 1 and out_ready is 0, the record stays unchanged and in_ready is 0. An input byte offered during that time is not consumed.
- R11: Cycles with in_valid low between the bytes of an instruction do not change the record that is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Record is complete |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | An addressing byte was present |
| out_modrm | output | 8 | Addressing byte, zero when absent |
| out_disp | output | 16 | Displacement or direct offset |
| out_imm | output | 16 | Immediate or far selector |
| out_len | output | 3 | Instruction length in bytes |
| out_illegal | output | 1 | Opcode not in the table |

## Verification
The assertions assume that the consumer follows the usual handshake: out_ready is meaningful only while out_valid is high. They also assume that the input stream never carries a partial instruction followed by a reset that is expected to resume it. The stimulus always completes each instruction before it starts the next one. It drives inputs and releases out_ready only on the falling edge. It raises out_ready only after the record has been checked, so each record-stability property sees a complete handshake.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 3;

    typedef enum logic [3:0] {
        ST_OP, ST_MODRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI, ST_SLO, ST_SHI, ST_DONE
    } pst_e;

    typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_WORD} immw_e;

    typedef struct packed {
        logic  legal;
        logic  modrm;
        logic  addr16;
        logic  far;
        immw_e immw;
    } opinfo_t;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic              has_modrm;
        logic [BYTE_W-1:0] modrm;
        logic [WORD_W-1:0] disp;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } irec_t;

    function automatic logic [WORD_W-1:0] sext8(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic logic [WORD_W-1:0] zext8(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction

    // Opcode table lookup: class of each supported opcode.
    function automatic opinfo_t classify(input logic [BYTE_W-1:0] b);
        opinfo_t r;
        r = '{legal: 1'b0, modrm: 1'b0, addr16: 1'b0, far: 1'b0, immw: IMM_NONE};
        if (b[7:3] == 5'b01000 || b[7:3] == 5'b01010) begin
            r.legal = 1'b1;                       // register in low three bits
        end else if (b[7:6] == 2'b00 && b[2:1] == 2'b11 && b[5] == 1'b0
                     && b != 8'h0F) begin
            r.legal = 1'b1;                       // segment push/pop short form
        end else begin
            case (b)
                8'h98, 8'h99, 8'hC3: r.legal = 1'b1;
                8'hC2, 8'h05: begin r.legal = 1'b1; r.immw = IMM_WORD; end
                8'hA1, 8'hA2: begin r.legal = 1'b1; r.addr16 = 1'b1; end
                8'hEA:        begin r.legal = 1'b1; r.far = 1'b1; end
                8'h81: begin r.legal = 1'b1; r.modrm = 1'b1; r.immw = IMM_WORD; end
                8'h83: begin r.legal = 1'b1; r.modrm = 1'b1; r.immw = IMM_BYTE; end
                8'h01, 8'h03, 8'h29, 8'h2B, 8'h88, 8'h89, 8'h8A, 8'h8B,
                8'h8C, 8'h8E, 8'hFE, 8'hFF: begin r.legal = 1'b1; r.modrm = 1'b1; end
                default: r.legal = 1'b0;
            endcase
        end
        return r;
    endfunction

    // State that follows the displacement (or the addressing byte).
    function automatic pst_e after_disp(input opinfo_t i);
        if (i.far)                 return ST_SLO;
        else if (i.immw != IMM_NONE) return ST_ILO;
        else                       return ST_DONE;
    endfunction

endpackage

// File: rtl/ilp_decode.sv
module ilp_decode
    import ilp_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output opinfo_t           info
);
    always_comb info = classify(opcode);
endmodule

// File: rtl/ilp_addr_len.sv
module ilp_addr_len (
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    output logic [1:0] disp_bytes
);
    always_comb begin
        case (mode)
            2'b01:   disp_bytes = 2'd1;
            2'b10:   disp_bytes = 2'd2;
            2'b00:   disp_bytes = (rm == 3'b110) ? 2'd2 : 2'd0;
            default: disp_bytes = 2'd0;
        endcase
    end
endmodule

// File: rtl/ilp_parser.sv
module ilp_parser
    import ilp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_opcode,
    output logic              out_has_modrm,
    output logic [BYTE_W-1:0] out_modrm,
    output logic [WORD_W-1:0] out_disp,
    output logic [WORD_W-1:0] out_imm,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_illegal
);
    pst_e    state;
    irec_t   rec;
    opinfo_t info_q;
    opinfo_t dec_info;
    logic    disp_two;
    logic [1:0] dsz;
    logic    take;

    ilp_decode u_dec (.opcode(in_byte), .info(dec_info));
    ilp_addr_len u_alen (.mode(in_byte[7:6]), .rm(in_byte[2:0]), .disp_bytes(dsz));

    assign in_ready  = (state != ST_DONE);
    assign out_valid = (state == ST_DONE);
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OP;
            rec      <= '0;
            info_q   <= '0;
            disp_two <= 1'b0;
        end else begin
            case (state)
                ST_OP: if (take) begin
                    rec        <= '0;
                    rec.opcode <= in_byte;
                    rec.len    <= LEN_W'(1);
                    info_q     <= dec_info;
                    disp_two   <= 1'b1;
                    if (!dec_info.legal) begin
                        rec.illegal <= 1'b1;
                        state       <= ST_DONE;
                    end else if (dec_info.modrm)
                        state <= ST_MODRM;
                    else if (dec_info.addr16 || dec_info.far)
                        state <= ST_DLO;
                    else if (dec_info.immw != IMM_NONE)
                        state <= ST_ILO;
                    else
                        state <= ST_DONE;
                end
                ST_MODRM: if (take) begin
                    rec.modrm     <= in_byte;
                    rec.has_modrm <= 1'b1;
                    rec.len       <= rec.len + LEN_W'(1);
                    case (dsz)
                        2'd1:    begin disp_two <= 1'b0; state <= ST_DLO; end
                        2'd2:    begin disp_two <= 1'b1; state <= ST_DLO; end
                        default: state <= after_disp(info_q);
                    endcase
                end
                ST_DLO: if (take) begin
                    rec.disp <= disp_two ? zext8(in_byte) : sext8(in_byte);
                    rec.len  <= rec.len + LEN_W'(1);
                    state    <= disp_two ? ST_DHI : after_disp(info_q);
                end
                ST_DHI: if (take) begin
                    rec.disp[WORD_W-1:BYTE_W] <= in_byte;
                    rec.len <= rec.len + LEN_W'(1);
                    state   <= after_disp(info_q);
                end
                ST_ILO: if (take) begin
                    rec.imm <= (info_q.immw == IMM_WORD) ? zext8(in_byte) : sext8(in_byte);
                    rec.len <= rec.len + LEN_W'(1);
                    state   <= (info_q.immw == IMM_WORD) ? ST_IHI : ST_DONE;
                end
                ST_IHI: if (take) begin
                    rec.imm[WORD_W-1:BYTE_W] <= in_byte;
                    rec.len <= rec.len + LEN_W'(1);
                    state   <= ST_DONE;
                end
                ST_SLO: if (take) begin
                    rec.imm <= zext8(in_byte);
                    rec.len <= rec.len + LEN_W'(1);
                    state   <= ST_SHI;
                end
                ST_SHI: if (take) begin
                    rec.imm[WORD_W-1:BYTE_W] <= in_byte;
                    rec.len <= rec.len + LEN_W'(1);
                    state   <= ST_DONE;
                end
                ST_DONE: if (out_ready) state <= ST_OP;
                default: state <= ST_OP;
            endcase
        end
    end

    assign out_opcode    = rec.opcode;
    assign out_has_modrm = rec.has_modrm;
    assign out_modrm     = rec.modrm;
    assign out_disp      = rec.disp;
    assign out_imm       = rec.imm;
    assign out_len       = rec.len;
    assign out_illegal   = rec.illegal;

    // R10
    hold_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && !in_ready && $stable(out_len)
            && $stable(out_disp) && $stable(out_imm) && $stable(out_opcode)));

    // R10
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

    // R9
    illegal_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_len == LEN_W'(1) && !out_has_modrm
            && out_disp == '0 && out_imm == '0));

    // R6
    modrm_len_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_has_modrm) |-> (out_len >= LEN_W'(2)));

    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len != '0 && out_len <= LEN_W'(6)));

endmodule

// File: tb/sim_ilp_parser.sv
module sim_ilp_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic        out_has_modrm;
    logic [7:0]  out_modrm;
    logic [15:0] out_disp;
    logic [15:0] out_imm;
    logic [2:0]  out_len;
    logic        out_illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ilp_parser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_has_modrm(out_has_modrm), .out_modrm(out_modrm),
        .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len),
        .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [47:0] bytes;   // first byte in bits 7..0
        logic [2:0]  n;
        logic [7:0]  op;
        logic        hm;
        logic [7:0]  modrm;
        logic [15:0] disp;
        logic [15:0] imm;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{48'h99,           3'd1, 8'h99, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h98,           3'd1, 8'h98, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'hC3,           3'd1, 8'hC3, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h43,           3'd1, 8'h43, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h57,           3'd1, 8'h57, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h06,           3'd1, 8'h06, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h1F,           3'd1, 8'h1F, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h0E,           3'd1, 8'h0E, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd2}, // R2
        '{48'h0008C2,       3'd3, 8'hC2, 1'b0, 8'h00, 16'h0000, 16'h0008, 1'b0, 4'd3}, // R3
        '{48'h000705,       3'd3, 8'h05, 1'b0, 8'h00, 16'h0000, 16'h0007, 1'b0, 4'd3}, // R3
        '{48'h0200A2,       3'd3, 8'hA2, 1'b0, 8'h00, 16'h0200, 16'h0000, 1'b0, 4'd4}, // R4
        '{48'h1234A1,       3'd3, 8'hA1, 1'b0, 8'h00, 16'h1234, 16'h0000, 1'b0, 4'd4}, // R4
        '{48'h12345678EA,   3'd5, 8'hEA, 1'b0, 8'h00, 16'h5678, 16'h1234, 1'b0, 4'd5}, // R5
        '{48'hC4FE,         3'd2, 8'hFE, 1'b1, 8'hC4, 16'h0000, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'h020006FF,     3'd4, 8'hFF, 1'b1, 8'h06, 16'h0200, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'h05598C,       3'd3, 8'h8C, 1'b1, 8'h59, 16'h0005, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'h1A2B8403,     3'd4, 8'h03, 1'b1, 8'h84, 16'h1A2B, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'hF6478B,       3'd3, 8'h8B, 1'b1, 8'h47, 16'hFFF6, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'h0088,         3'd2, 8'h88, 1'b1, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd6}, // R6
        '{48'h1A2B0E0FAF81, 3'd6, 8'h81, 1'b1, 8'hAF, 16'h0E0F, 16'h1A2B, 1'b0, 4'd7}, // R7
        '{48'h1A2B02002E81, 3'd6, 8'h81, 1'b1, 8'h2E, 16'h0200, 16'h1A2B, 1'b0, 4'd7}, // R7
        '{48'h05F983,       3'd3, 8'h83, 1'b1, 8'hF9, 16'h0000, 16'h0005, 1'b0, 4'd8}, // R8
        '{48'hFB2F83,       3'd3, 8'h83, 1'b1, 8'h2F, 16'h0000, 16'hFFFB, 1'b0, 4'd8}, // R8
        '{48'h80FC4683,     3'd4, 8'h83, 1'b1, 8'h46, 16'hFFFC, 16'hFF80, 1'b0, 4'd8}, // R8
        '{48'h0F,           3'd1, 8'h0F, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 4'd9}, // R9
        '{48'h90,           3'd1, 8'h90, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 4'd9}, // R9
        '{48'h48,           3'd1, 8'h48, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 4'd9}  // R9
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int gap, input string req);
        for (int i = 0; i < int'(v.n); i++) begin
            if (i != 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_byte  = 8'hEE;
                end
            end
            send_byte(v.bytes[i*8 +: 8]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {15'd0, out_valid}, 16'd1);
        check(req, "opcode", {8'd0, out_opcode}, {8'd0, v.op});
        check(req, "has_modrm", {15'd0, out_has_modrm}, {15'd0, v.hm});
        check(req, "modrm", {8'd0, out_modrm}, {8'd0, v.modrm});
        check(req, "disp", out_disp, v.disp);
        check(req, "imm", out_imm, v.imm);
        check(req, "len", {13'd0, out_len}, {13'd0, v.n});
        check(req, "illegal", {15'd0, out_illegal}, {15'd0, v.ill});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "in_ready", {15'd0, in_ready}, 16'd1);

        for (int k = 0; k < NV; k++)
            run_vec(VECS[k], 0, $sformatf("R%0d", VECS[k].req));

        // R11: bubbles between bytes
        run_vec(VECS[23], 2, "R11");
        run_vec(VECS[19], 3, "R11");

        // R10: back-pressure holds record, extra byte not consumed
        for (int i = 0; i < 6; i++) send_byte(VECS[19].bytes[i*8 +: 8]);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h99;
        for (int c = 0; c < 5; c++) begin
            check("R10", "out_valid held", {15'd0, out_valid}, 16'd1);
            check("R10", "in_ready low", {15'd0, in_ready}, 16'd0);
            check("R10", "len held", {13'd0, out_len}, 16'd6);
            check("R10", "imm held", out_imm, 16'h1A2B);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "next opcode", {8'd0, out_opcode}, 16'h0099);
        check("R10", "next len", {13'd0, out_len}, 16'd1);
        check("R10", "next valid", {15'd0, out_valid}, 16'd1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;

        finished = 1'b1;
        finish_run();
    end
endmodule